// File: doc/BRIEF.md
# Lane-Replicated Integer Execute Stage

This block is the integer execute stage of a small register machine with eight 64-bit registers. It takes one decoded instruction, reads its operands from an external register file, and builds the second operand in one of four ways: a sign-extended immediate, the immediate plus a register, a memory word fetched at that sum, or a memory word fetched the same way with a register post-increment. The operand is pre-scaled by a left shift. The selected operation then runs independently in every lane of the chosen width (8, 16, 32 or 64 bits) across the full register. The result either replaces the destination register or is added to it lane by lane.

Each accepted instruction takes a fixed three-cycle sequence. In the first cycle the sources are read. In the second cycle the destination is read and any memory read is issued. In the third cycle the result, and any post-increment, are written, and completion is signalled. Opcode groups outside the four defined ones finish in the same number of cycles with an illegal-instruction strobe and change no register.

Top module: `laneAluExec`

## Requirements
- R1: `laneWidth` selects the lane size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Every lane of the 64-bit word is computed independently, with no carry or shift crossing a lane boundary.
- R2: With `srcMode` = 0, the operand is `imm` sign-extended to 64 bits. Each lane of it is shifted left by `preShift` modulo the lane width.
- R3: With `srcMode` = 1, the operand is the 64-bit sum of the sign-extended `imm` and register c, then pre-shifted per lane as in R2.
- R4: With `srcMode` = 2, the block raises `memRdEn` in the second cycle. `memAddr` is the sum of the sign-extended `imm` and register c, with its low three bits cleared. The word returned on `memRdData` one cycle later is the operand, pre-shifted per lane.
- R5: `srcMode` = 3 behaves as mode 2. In the result cycle the block also raises `incEn` with `incAddr` = c and `incData` = c + 8. When the destination equals c, the post-increment is suppressed and only the result is written.
- R6: With `accum` = 1, each lane of the result is added, modulo the lane size, to the matching lane of the old destination value, and that sum is written.
- R7: `opGroup` 0 = signed multiply keeping the low lane bits. 1 = b minus operand. 2 = arithmetic right shift of b. 3 = left shift of b. For the shifts, the amount is the operand lane modulo the lane width.
- R8: `opGroup` 0 combined with `srcMode` 1 performs lane-wise addition b + operand instead of multiplication.
- R9: `opGroup` values 4 to 7 raise `illegal` together with `done` and raise neither `wrEn` nor `incEn`.
- R10: `done` rises exactly three cycles after the cycle in which `start` is accepted. `start` is accepted only while idle and is ignored while busy. `rdAddrA`/`rdAddrB` carry b/c in the first cycle, and `rdAddrA` carries the destination in the second. Writes occur only in the `done` cycle.
- R11: After reset, `done`, `wrEn`, `incEn`, `memRdEn` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue the instruction presented on the fields below |
| opGroup | input | 3 | Operation group |
| laneWidth | input | 2 | Lane size code |
| srcMode | input | 2 | Second-operand forming mode |
| accum | input | 1 | Add result into destination |
| dstSel | input | 3 | Destination register index |
| bSel | input | 3 | First-operand register index |
| cSel | input | 3 | Offset / index register |
| imm | input | 16 | Signed immediate |
| preShift | input | 6 | Operand pre-scale left shift |
| rdAddrA | output | 3 | Register read port A address |
| rdDataA | input | 64 | Register read port A data (same cycle) |
| rdAddrB | output | 3 | Register read port B address |
| rdDataB | input | 64 | Register read port B data (same cycle) |
| wrEn | output | 1 | Result write enable |
| wrAddr | output | 3 | Result write index |
| wrData | output | 64 | Result write data |
| incEn | output | 1 | Post-increment write enable |
| incAddr | output | 3 | Post-increment write index |
| incData | output | 64 | Post-increment write data |
| memRdEn | output | 1 | Data-memory read request |
| memAddr | output | 64 | Aligned data-memory byte address |
| memRdData | input | 64 | Data-memory word, valid the cycle after the request |
| done | output | 1 | Instruction complete |
| illegal | output | 1 | Undefined operation group (with done) |

## Verification
The result write and the post-increment write fall in the same cycle in mode 3. The bench provokes this with distinct destination and index registers and expects both writes together. It then makes the destination equal the index register and expects only the result write, with the register afterwards holding the result rather than the incremented index. A second overlap is accumulation on top of a memory-sourced operand. There, the old destination read and the memory request share one cycle, and the final value is compared against a lane-wise model fed with the same memory pattern.

// File: rtl/laneAluPkg.sv
package laneAluPkg;
  localparam int DATA_W     = 64;
  localparam int REG_AW     = 3;
  localparam int IMM_W      = 16;
  localparam int PRE_W      = 6;
  localparam int GRP_W      = 3;
  localparam int NUM_WIDTHS = 4;
  localparam int ALIGN_BITS = $clog2(DATA_W / 8);
  localparam int INC_STEP   = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_FETCH,
    ST_EXEC
  } aluState_e;

  typedef struct packed {
    logic [GRP_W-1:0]  opGroup;
    logic [1:0]        laneWidth;
    logic [1:0]        srcMode;
    logic              accum;
    logic [REG_AW-1:0] dstSel;
    logic [REG_AW-1:0] bSel;
    logic [REG_AW-1:0] cSel;
    logic [IMM_W-1:0]  imm;
    logic [PRE_W-1:0]  preShift;
  } instr_t;

  typedef struct packed {
    logic latchOps;
    logic latchDst;
  } dpCtl_t;
endpackage

// File: rtl/laneAluCtrl.sv
module laneAluCtrl
  import laneAluPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  instr_t instrIn,
  output instr_t instrQ,
  output dpCtl_t dpCtl,
  output logic   accept,
  output logic   memRdEn,
  output logic   wrEn,
  output logic   incEn,
  output logic   done,
  output logic   illegal
);
  aluState_e state;
  logic legalOp;

  assign accept  = start && (state == ST_IDLE);
  assign legalOp = !instrQ.opGroup[GRP_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      instrQ <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (accept) begin
                    state  <= ST_READ;
                    instrQ <= instrIn;
                  end
        ST_READ:  state <= ST_FETCH;
        ST_FETCH: state <= ST_EXEC;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtl.latchOps = (state == ST_READ);
    dpCtl.latchDst = (state == ST_FETCH);
    memRdEn = (state == ST_FETCH) && legalOp && instrQ.srcMode[1];
    wrEn    = (state == ST_EXEC) && legalOp;
    incEn   = (state == ST_EXEC) && legalOp && (instrQ.srcMode == 2'd3)
              && (instrQ.dstSel != instrQ.cSel);
    done    = (state == ST_EXEC);
    illegal = (state == ST_EXEC) && !legalOp;
  end
endmodule

// File: rtl/laneAluDatapath.sv
module laneAluDatapath
  import laneAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [1:0]        opSel,
  input  logic [1:0]        laneWidth,
  input  logic [1:0]        srcMode,
  input  logic              accum,
  input  logic [IMM_W-1:0]  imm,
  input  logic [PRE_W-1:0]  preShift,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] incData
);
  logic [DATA_W-1:0] bVal, cVal, dVal;
  logic [DATA_W-1:0] immExt, addrSum, operandRaw;
  logic [DATA_W-1:0] resByWidth [NUM_WIDTHS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bVal <= '0;
      cVal <= '0;
      dVal <= '0;
    end else begin
      if (dpCtl.latchOps) begin
        bVal <= rdDataA;
        cVal <= rdDataB;
      end
      if (dpCtl.latchDst) dVal <= rdDataA;
    end
  end

  assign immExt  = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign addrSum = immExt + cVal;
  assign memAddr = {addrSum[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign incData = cVal + DATA_W'(INC_STEP);

  always_comb begin
    unique case (srcMode)
      2'd0:    operandRaw = immExt;
      2'd1:    operandRaw = addrSum;
      default: operandRaw = memRdData;
    endcase
  end

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : gWidth
    localparam int LW = 8 << g;
    localparam int LN = DATA_W / LW;
    localparam int SW = $clog2(LW);
    logic [DATA_W-1:0] laneRes;

    for (genvar l = 0; l < LN; l++) begin : gLane
      logic [LW-1:0] bL, dL, opL, opRes, laneOut;
      logic [SW-1:0] amt;

      always_comb begin
        bL  = bVal[l*LW +: LW];
        dL  = dVal[l*LW +: LW];
        opL = operandRaw[l*LW +: LW] << preShift[SW-1:0];
        amt = opL[SW-1:0];
        unique case (opSel)
          2'd0:    opRes = (srcMode == 2'd1) ? bL + opL : bL * opL;
          2'd1:    opRes = bL - opL;
          2'd2:    opRes = $signed(bL) >>> amt;
          default: opRes = bL << amt;
        endcase
        laneOut = accum ? dL + opRes : opRes;
      end

      assign laneRes[l*LW +: LW] = laneOut;
    end

    assign resByWidth[g] = laneRes;
  end

  assign wrData = resByWidth[laneWidth];
endmodule

// File: rtl/laneAluExec.sv
module laneAluExec
  import laneAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [GRP_W-1:0]  opGroup,
  input  logic [1:0]        laneWidth,
  input  logic [1:0]        srcMode,
  input  logic              accum,
  input  logic [REG_AW-1:0] dstSel,
  input  logic [REG_AW-1:0] bSel,
  input  logic [REG_AW-1:0] cSel,
  input  logic [IMM_W-1:0]  imm,
  input  logic [PRE_W-1:0]  preShift,
  output logic [REG_AW-1:0] rdAddrA,
  input  logic [DATA_W-1:0] rdDataA,
  output logic [REG_AW-1:0] rdAddrB,
  input  logic [DATA_W-1:0] rdDataB,
  output logic              wrEn,
  output logic [REG_AW-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              incEn,
  output logic [REG_AW-1:0] incAddr,
  output logic [DATA_W-1:0] incData,
  output logic              memRdEn,
  output logic [DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              done,
  output logic              illegal
);
  instr_t instrIn, instrQ;
  dpCtl_t dpCtl;
  logic   accept;

  assign instrIn = '{opGroup: opGroup, laneWidth: laneWidth, srcMode: srcMode,
                     accum: accum, dstSel: dstSel, bSel: bSel, cSel: cSel,
                     imm: imm, preShift: preShift};

  laneAluCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .instrIn(instrIn),
    .instrQ(instrQ), .dpCtl(dpCtl), .accept(accept), .memRdEn(memRdEn),
    .wrEn(wrEn), .incEn(incEn), .done(done), .illegal(illegal)
  );

  laneAluDatapath uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .opSel(instrQ.opGroup[1:0]), .laneWidth(instrQ.laneWidth),
    .srcMode(instrQ.srcMode), .accum(instrQ.accum), .imm(instrQ.imm),
    .preShift(instrQ.preShift), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .memRdData(memRdData), .memAddr(memAddr), .wrData(wrData),
    .incData(incData)
  );

  assign rdAddrA = dpCtl.latchOps ? instrQ.bSel : instrQ.dstSel;
  assign rdAddrB = instrQ.cSel;
  assign wrAddr  = instrQ.dstSel;
  assign incAddr = instrQ.cSel;
endmodule

// File: rtl/laneAluChecker.sv
module laneAluChecker (
  input logic        clk,
  input logic        rstN,
  input logic        accept,
  input logic        done,
  input logic        illegal,
  input logic        wrEn,
  input logic        incEn,
  input logic        memRdEn,
  input logic [2:0]  wrAddr,
  input logic [2:0]  incAddr,
  input logic [63:0] memAddr
);
  p_done_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> ##3 done);

  p_write_in_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!wrEn && !incEn));

  p_illegal_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (done && !wrEn && !incEn));

  p_inc_distinct_r5: assert property (@(posedge clk) disable iff (!rstN)
    incEn |-> (wrEn && incAddr != wrAddr));

  p_mem_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memAddr[2:0] == 3'b000));

  p_mem_then_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (done && wrEn));
endmodule

bind laneAluExec laneAluChecker uChk (
  .clk(clk), .rstN(rstN), .accept(accept), .done(done), .illegal(illegal),
  .wrEn(wrEn), .incEn(incEn), .memRdEn(memRdEn), .wrAddr(wrAddr),
  .incAddr(incAddr), .memAddr(memAddr)
);

// File: tb/laneAluExec_test.sv
module laneAluExec_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opGroup = '0;
  logic [1:0]  laneWidth = '0, srcMode = '0;
  logic        accum = 1'b0;
  logic [2:0]  dstSel = '0, bSel = '0, cSel = '0;
  logic [15:0] imm = '0;
  logic [5:0]  preShift = '0;
  logic [2:0]  rdAddrA, rdAddrB, wrAddr, incAddr;
  logic [63:0] rdDataA, rdDataB, wrData, incData, memAddr;
  logic [63:0] memRdData = '0;
  logic        wrEn, incEn, memRdEn, done, illegal;
  logic [63:0] regs [8];
  int vectors = 0;
  int misses = 0;

  always #2 clk = ~clk;

  laneAluExec uut (
    .clk(clk), .rstN(rstN), .start(start), .opGroup(opGroup),
    .laneWidth(laneWidth), .srcMode(srcMode), .accum(accum), .dstSel(dstSel),
    .bSel(bSel), .cSel(cSel), .imm(imm), .preShift(preShift),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .incEn(incEn),
    .incAddr(incAddr), .incData(incData), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .done(done), .illegal(illegal)
  );

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  function automatic logic [63:0] memWord(input logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A_3C3C, a[31:0] + 32'h1357_9BDF};
  endfunction

  always @(posedge clk) begin
    if (wrEn) regs[wrAddr] <= wrData;
    if (incEn) regs[incAddr] <= incData;
    if (memRdEn) memRdData <= memWord(memAddr);
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [2:0] grp, input logic [1:0] w,
      input logic [1:0] m, input logic acc, input logic [63:0] bv, input logic [63:0] cv,
      input logic [63:0] dv, input logic [15:0] im, input logic [5:0] pre,
      input logic [63:0] mw);
    int lw = 8 << w;
    logic [63:0] mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    logic [63:0] sext = {{48{im[15]}}, im};
    logic [63:0] base = (m == 2'd0) ? sext : (m == 2'd1) ? sext + cv : mw;
    logic [63:0] res = '0;
    for (int l = 0; l < 64 / lw; l++) begin
      logic [63:0] x, bl, dl, r, amt;
      logic signed [63:0] sb;
      x   = (base >> (l * lw)) & mask;
      x   = (x << (pre % lw)) & mask;
      bl  = (bv >> (l * lw)) & mask;
      dl  = (dv >> (l * lw)) & mask;
      sb  = $signed(bl << (64 - lw)) >>> (64 - lw);
      amt = x % lw;
      case (grp)
        3'd0:    r = (m == 2'd1) ? bl + x : bl * x;
        3'd1:    r = bl - x;
        3'd2:    r = 64'(sb >>> amt);
        default: r = bl << amt;
      endcase
      r = r & mask;
      if (acc) r = (dl + r) & mask;
      res = res | (r << (l * lw));
    end
    return res;
  endfunction

  task automatic runOp(input string tag, input logic [2:0] grp, input logic [1:0] w,
      input logic [1:0] m, input logic acc, input logic [2:0] d, input logic [2:0] b,
      input logic [2:0] c, input logic [15:0] im, input logic [5:0] pre);
    logic [63:0] bv = regs[b], cv = regs[c], dv = regs[d];
    logic [63:0] addr = ({{48{im[15]}}, im} + cv) & ~64'd7;
    logic [63:0] expv = model(grp, w, m, acc, bv, cv, dv, im, pre, memWord(addr));
    logic legal = !grp[2];
    logic expInc = legal && (m == 2'd3) && (d != c);
    opGroup = grp; laneWidth = w; srcMode = m; accum = acc;
    dstSel = d; bSel = b; cSel = c; imm = im; preShift = pre;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R10 busy no done"}, 64'(done), 64'd0);
    chk({tag, " R10 read ports"}, {58'd0, rdAddrA, rdAddrB}, {58'd0, b, c});
    @(negedge clk);
    chk({tag, " R10 dst read"}, 64'(rdAddrA), 64'(d));
    chk({tag, " R4 memRdEn"}, 64'(memRdEn), 64'(legal && m[1]));
    if (legal && m[1]) chk({tag, " R4 memAddr"}, memAddr, addr);
    @(negedge clk);
    chk({tag, " R10 done"}, 64'(done), 64'd1);
    chk({tag, " R9 illegal"}, 64'(illegal), 64'(!legal));
    chk({tag, " R9 wrEn"}, 64'(wrEn), 64'(legal));
    chk({tag, " R5 incEn"}, 64'(incEn), 64'(expInc));
    if (legal) chk({tag, " result"}, wrData, expv);
    if (expInc) chk({tag, " R5 incData"}, incData, cv + 64'd8);
    @(negedge clk);
    chk({tag, " regfile dst"}, regs[d], legal ? expv : dv);
    if (expInc) chk({tag, " R5 regfile c"}, regs[c], cv + 64'd8);
  endtask

  task automatic testReset();
    chk("R11 reset outputs", {59'd0, done, wrEn, incEn, memRdEn, illegal}, 64'd0);
  endtask

  task automatic testImmediate();
    runOp("R2 R7 mul 8b", 3'd0, 2'd0, 2'd0, 1'b0, 3'd3, 3'd1, 3'd2, 16'h0003, 6'd0);
    runOp("R1 R2 sub 16b pre mod", 3'd1, 2'd1, 2'd0, 1'b0, 3'd4, 3'd2, 3'd0, 16'hFFF1, 6'd19);
    runOp("R1 R7 mul 32b", 3'd0, 2'd2, 2'd0, 1'b0, 3'd5, 3'd6, 3'd0, 16'h8123, 6'd2);
    runOp("R1 R7 sub 64b", 3'd1, 2'd3, 2'd0, 1'b0, 3'd6, 3'd7, 3'd0, 16'h7FFF, 6'd40);
    runOp("R2 pre 13 on 8b", 3'd1, 2'd0, 2'd0, 1'b0, 3'd7, 3'd1, 3'd0, 16'h0101, 6'd13);
  endtask

  task automatic testRegOffset();
    runOp("R8 add mode1", 3'd0, 2'd0, 2'd1, 1'b0, 3'd2, 3'd3, 3'd4, 16'h0011, 6'd1);
    runOp("R3 sub mode1", 3'd1, 2'd2, 2'd1, 1'b0, 3'd0, 3'd5, 3'd6, 16'hFF00, 6'd3);
  endtask

  task automatic testMemory();
    runOp("R4 mem mul 16b", 3'd0, 2'd1, 2'd2, 1'b0, 3'd1, 3'd2, 3'd3, 16'hFFFB, 6'd0);
    runOp("R4 mem sub 64b", 3'd1, 2'd3, 2'd2, 1'b0, 3'd4, 3'd5, 3'd6, 16'h0027, 6'd4);
  endtask

  task automatic testPostInc();
    runOp("R5 postinc", 3'd1, 2'd2, 2'd3, 1'b0, 3'd7, 3'd0, 3'd2, 16'h0010, 6'd0);
    runOp("R5 postinc collision", 3'd0, 2'd0, 2'd3, 1'b0, 3'd2, 3'd1, 3'd2, 16'h0008, 6'd1);
  endtask

  task automatic testAccum();
    runOp("R6 acc mode0", 3'd1, 2'd0, 2'd0, 1'b1, 3'd3, 3'd4, 3'd5, 16'h0042, 6'd0);
    runOp("R6 acc mode1 add", 3'd0, 2'd1, 2'd1, 1'b1, 3'd6, 3'd1, 3'd2, 16'h1234, 6'd0);
    runOp("R6 acc mode2", 3'd0, 2'd2, 2'd2, 1'b1, 3'd0, 3'd3, 3'd4, 16'h0100, 6'd0);
    runOp("R6 acc mode3", 3'd1, 2'd3, 2'd3, 1'b1, 3'd5, 3'd6, 3'd7, 16'h0000, 6'd0);
  endtask

  task automatic testShifts();
    regs[1] = 64'h8040_F00F_8001_7FFE;
    runOp("R7 asr 8b amt mod", 3'd2, 2'd0, 2'd0, 1'b0, 3'd2, 3'd1, 3'd0, 16'h000B, 6'd0);
    runOp("R7 asr 16b", 3'd2, 2'd1, 2'd0, 1'b0, 3'd3, 3'd1, 3'd0, 16'h0004, 6'd0);
    runOp("R7 asl 32b amt mod", 3'd3, 2'd2, 2'd0, 1'b0, 3'd4, 3'd1, 3'd0, 16'h0025, 6'd0);
    runOp("R7 asr 64b", 3'd2, 2'd3, 2'd0, 1'b0, 3'd5, 3'd1, 3'd0, 16'h0007, 6'd0);
  endtask

  task automatic testIllegal();
    runOp("R9 group4", 3'd4, 2'd0, 2'd3, 1'b0, 3'd1, 3'd2, 3'd3, 16'h0001, 6'd0);
    runOp("R9 group7", 3'd7, 2'd3, 2'd0, 1'b1, 3'd6, 3'd6, 3'd6, 16'hFFFF, 6'd5);
  endtask

  task automatic testBusy();
    logic [63:0] expv = model(3'd1, 2'd3, 2'd0, 1'b0, regs[1], regs[2], regs[5],
                              16'h0003, 6'd0, 64'd0);
    int extra = 0;
    opGroup = 3'd1; laneWidth = 2'd3; srcMode = 2'd0; accum = 1'b0;
    dstSel = 3'd5; bSel = 3'd1; cSel = 3'd2; imm = 16'h0003; preShift = 6'd0;
    start = 1'b1;
    @(negedge clk);
    dstSel = 3'd6; imm = 16'h0100;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R10 busy first done", 64'(done), 64'd1);
    chk("R10 busy wrAddr", 64'(wrAddr), 64'd5);
    chk("R10 busy wrData", wrData, expv);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R10 start ignored while busy", 64'(extra), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++)
      regs[i] = {8{8'(i * 37 + 11)}} ^ (64'h0F1E_2D3C_4B5A_6978 * 64'(i + 1));
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testImmediate();
    testRegOffset();
    testMemory();
    testPostInc();
    testAccum();
    testShifts();
    testIllegal();
    testBusy();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule